// File: doc/BRIEF.md
# Multi-Stream Sequential Line Prefetcher

This block sits next to a first-level cache and turns cache misses into sequential prefetch streams. Each lookup presents the line address that just missed in the cache. If that address equals the oldest line held by one of the stream buffers, the buffer hands the line to the cache, drops it, and asks the next memory level for the line that now lies one buffer depth further ahead. If no buffer holds the address at its oldest position, the least recently used buffer is discarded and restarted on the lines that follow the miss. The cache then fills that miss from the next level itself.

Prefetched lines live only in the buffers and reach the cache through lookups. Several buffers run side by side, so a few interleaved sequential streams can be followed at once. Requests to the next level carry a tag naming the buffer and the slot. Responses may come back in any order, and several requests may be outstanding at the same time.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset no buffer is active, `missReady` is 1, `respValid` is 0 and `reqValid` is 0.
- R2: A lookup whose address matches no buffer's oldest line is accepted in the same cycle. One cycle later `respValid`=1 and `respHit`=0.
- R3: After a miss on line address A starts a buffer, that buffer issues exactly DEPTH requests, for lines A+1 through A+DEPTH, and then issues no more until a line is taken from it.
- R4: A lookup that matches a buffer's oldest line whose data has arrived is accepted in the same cycle. One cycle later `respValid`=1, `respHit`=1 and `respData` equals the data returned for that line.
- R5: Every line taken from a buffer triggers a request for the line DEPTH positions past it, so a stream keeps hitting well beyond the buffer depth.
- R6: A lookup that matches a buffer's oldest line whose data is still outstanding holds `missReady` at 0 until the data arrives. It then completes as in R4.
- R7: Buffers track interleaved sequential streams independently of each other.
- R8: A miss replaces the least recently used buffer, where both a hit and an allocation count as a use. After reset the recency order, from least to most recent, is buffer NUM_BUF-1 down to buffer 0.
- R9: `reqTag` is {buffer index, slot index}, with the buffer index in the upper bits. A response is routed by its echoed tag alone, in any order. `rspValid` is always accepted.
- R10: A response to a request made before its buffer was restarted is discarded and never delivered. No tag is issued again while a response for it is outstanding.
- R11: Only the oldest line of a buffer is compared. A lookup for a line held deeper in a buffer is a miss and restarts a buffer.
- R12: `respValid` is raised only in the cycle after an accepted lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Cache-miss lookup present |
| missAddr | input | ADDR_W | Line address of the miss |
| missReady | output | 1 | Lookup accepted this cycle |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | Line supplied from a buffer |
| respData | output | DATA_W | Supplied line data |
| reqValid | output | 1 | Next-level line request |
| reqReady | input | 1 | Next level accepts request |
| reqAddr | output | ADDR_W | Requested line address |
| reqTag | output | log2(NUM_BUF)+log2(DEPTH) | Buffer and slot of the request |
| rspValid | input | 1 | Next-level response valid |
| rspTag | input | log2(NUM_BUF)+log2(DEPTH) | Echoed request tag |
| rspData | input | DATA_W | Returned line data |

## Verification
The bench restarts a buffer while all of its requests are still outstanding and then runs the new stream. If stale responses were not dropped, old lines would be delivered as hits with the wrong data. It holds back responses so that a lookup meets a pending oldest line; a design that did not stall would return a hit with garbage, or a false miss. The stimulus sweeps one to five interleaved streams against a reference recency model, which catches wrong victim choice, hits reported on lines deeper in a buffer, and refills aimed at the wrong address. Responses are returned in a scrambled order, so any tag mix-up corrupts the data compared against each line.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Outcome of one lookup as seen by the control block.
  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_HIT   = 2'd1,
    LK_MISS  = 2'd2,
    LK_STALL = 2'd3
  } lookupKind_e;

  // Default strobe layout (matches NUM_BUF = 4); the top supplies its own.
  typedef struct packed {
    logic       popEn;
    logic       allocEn;
    logic [1:0] bufSel;
  } sbStrobeDefault_t;

endpackage

// File: rtl/sb_lru.sv
module sb_lru #(
  parameter int NUM_BUF = 4,
  localparam int BUF_W = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             touchEn,
  input  logic [BUF_W-1:0] touchBuf,
  output logic [BUF_W-1:0] lruBuf
);

  // age 0 = most recent, NUM_BUF-1 = least recent
  logic [BUF_W-1:0] age [NUM_BUF];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) age[i] <= BUF_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (BUF_W'(i) == touchBuf) age[i] <= '0;
        else if (age[i] < age[touchBuf]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lruBuf = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (age[i] == BUF_W'(NUM_BUF - 1)) lruBuf = BUF_W'(i);
    end
  end

endmodule

// File: rtl/sb_slot.sv
module sb_slot #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rspHere,
  input  logic [DATA_W-1:0] rspData,
  input  logic              issueHere,
  input  logic              allocHere,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              popHere,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              validOut,
  output logic              needOut,
  output logic              busyOut
);

  logic stale;
  logic busyAfter;

  // still waiting on the next level once this edge has been applied
  assign busyAfter = issueHere | (busyOut & ~rspHere);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut  <= '0;
      dataOut  <= '0;
      validOut <= 1'b0;
      needOut  <= 1'b0;
      busyOut  <= 1'b0;
      stale    <= 1'b0;
    end else begin
      if (rspHere) begin
        busyOut <= 1'b0;
        if (stale) begin
          stale <= 1'b0;
        end else begin
          validOut <= 1'b1;
          dataOut  <= rspData;
        end
      end
      if (issueHere) begin
        busyOut <= 1'b1;
        needOut <= 1'b0;
      end
      if (allocHere) begin
        addrOut  <= allocAddr;
        validOut <= 1'b0;
        needOut  <= 1'b1;
        stale    <= busyAfter;
      end
      if (popHere) begin
        addrOut  <= addrOut + ADDR_W'(DEPTH);
        validOut <= 1'b0;
        needOut  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sb_datapath.sv
module sb_datapath #(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter type strobe_t = sb_pkg::sbStrobeDefault_t,
  localparam int BUF_W  = $clog2(NUM_BUF),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int TAG_W  = BUF_W + SLOT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [ADDR_W-1:0]  missAddr,
  output logic [NUM_BUF-1:0] headHitVec,
  output logic [NUM_BUF-1:0] headReadyVec,
  output logic [DATA_W-1:0]  respData,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [TAG_W-1:0]   reqTag,
  input  logic               rspValid,
  input  logic [TAG_W-1:0]   rspTag,
  input  logic [DATA_W-1:0]  rspData
);

  localparam int NSLOT = NUM_BUF * DEPTH;

  logic [ADDR_W-1:0] slotAddr [NSLOT];
  logic [DATA_W-1:0] slotData [NSLOT];
  logic [NSLOT-1:0]  slotValid;
  logic [NSLOT-1:0]  slotNeed;
  logic [NSLOT-1:0]  slotBusy;

  logic [SLOT_W-1:0] headPtr [NUM_BUF];
  logic [NUM_BUF-1:0] active;

  logic [TAG_W-1:0] issueIdx;
  logic             issueFire;
  logic [TAG_W-1:0] popIdx;

  // buffer state: head pointer and active flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BUF; b++) headPtr[b] <= '0;
      active <= '0;
    end else if (strobe.allocEn) begin
      headPtr[strobe.bufSel] <= '0;
      active[strobe.bufSel]  <= 1'b1;
    end else if (strobe.popEn) begin
      headPtr[strobe.bufSel] <= headPtr[strobe.bufSel] + 1'b1;
    end
  end

  // per-buffer head compare
  for (genvar b = 0; b < NUM_BUF; b++) begin : g_head
    logic [TAG_W-1:0] headIdx;
    assign headIdx         = {BUF_W'(b), headPtr[b]};
    assign headHitVec[b]   = active[b] && (slotAddr[headIdx] == missAddr);
    assign headReadyVec[b] = slotValid[headIdx];
  end

  // per-slot storage
  for (genvar f = 0; f < NSLOT; f++) begin : g_slot
    localparam int B = f / DEPTH;
    localparam int S = f % DEPTH;
    logic rspHere;
    logic issueHere;
    logic allocHere;
    logic popHere;

    assign rspHere   = rspValid && (rspTag == TAG_W'(f));
    assign issueHere = issueFire && (issueIdx == TAG_W'(f));
    assign allocHere = strobe.allocEn && (strobe.bufSel == BUF_W'(B));
    assign popHere   = strobe.popEn && (strobe.bufSel == BUF_W'(B)) &&
                       (headPtr[B] == SLOT_W'(S));

    sb_slot #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .DEPTH (DEPTH)
    ) u_slot (
      .clk      (clk),
      .rstN     (rstN),
      .rspHere  (rspHere),
      .rspData  (rspData),
      .issueHere(issueHere),
      .allocHere(allocHere),
      .allocAddr(missAddr + ADDR_W'(S + 1)),
      .popHere  (popHere),
      .addrOut  (slotAddr[f]),
      .dataOut  (slotData[f]),
      .validOut (slotValid[f]),
      .needOut  (slotNeed[f]),
      .busyOut  (slotBusy[f])
    );
  end

  // request arbiter: lowest flat slot index first
  always_comb begin
    reqValid = 1'b0;
    issueIdx = '0;
    for (int f = NSLOT - 1; f >= 0; f--) begin
      if (slotNeed[f] && !slotBusy[f]) begin
        reqValid = 1'b1;
        issueIdx = TAG_W'(f);
      end
    end
  end

  assign issueFire = reqValid && reqReady;
  assign reqAddr   = slotAddr[issueIdx];
  assign reqTag    = issueIdx;

  // delivered line register
  assign popIdx = {strobe.bufSel, headPtr[strobe.bufSel]};

  always_ff @(posedge clk) begin
    if (!rstN) respData <= '0;
    else if (strobe.popEn) respData <= slotData[popIdx];
  end

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int NUM_BUF = 4,
  parameter type strobe_t = sb_pkg::sbStrobeDefault_t,
  localparam int BUF_W = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               missValid,
  input  logic [NUM_BUF-1:0] headHitVec,
  input  logic [NUM_BUF-1:0] headReadyVec,
  input  logic [BUF_W-1:0]   lruBuf,
  output logic               missReady,
  output logic               respValid,
  output logic               respHit,
  output logic               hitAny,
  output strobe_t            strobe
);
  import sb_pkg::*;

  logic [BUF_W-1:0] hitBuf;
  lookupKind_e      kind;

  always_comb begin
    hitBuf = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (headHitVec[b]) hitBuf = BUF_W'(b);
    end
  end

  assign hitAny = |headHitVec;

  always_comb begin
    if (!missValid)              kind = LK_IDLE;
    else if (!hitAny)            kind = LK_MISS;
    else if (headReadyVec[hitBuf]) kind = LK_HIT;
    else                         kind = LK_STALL;
  end

  assign missReady = (kind != LK_STALL);

  always_comb begin
    strobe         = '0;
    strobe.popEn   = (kind == LK_HIT);
    strobe.allocEn = (kind == LK_MISS);
    strobe.bufSel  = hitAny ? hitBuf : lruBuf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
    end else begin
      respValid <= (kind == LK_HIT) || (kind == LK_MISS);
      respHit   <= (kind == LK_HIT);
    end
  end

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic                                       missValid,
  input  logic [ADDR_W-1:0]                          missAddr,
  output logic                                       missReady,
  output logic                                       respValid,
  output logic                                       respHit,
  output logic [DATA_W-1:0]                          respData,
  output logic                                       reqValid,
  input  logic                                       reqReady,
  output logic [ADDR_W-1:0]                          reqAddr,
  output logic [$clog2(NUM_BUF)+$clog2(DEPTH)-1:0]   reqTag,
  input  logic                                       rspValid,
  input  logic [$clog2(NUM_BUF)+$clog2(DEPTH)-1:0]   rspTag,
  input  logic [DATA_W-1:0]                          rspData
);

  localparam int BUF_W = $clog2(NUM_BUF);
  localparam int TAG_W = BUF_W + $clog2(DEPTH);

  typedef struct packed {
    logic             popEn;
    logic             allocEn;
    logic [BUF_W-1:0] bufSel;
  } strobe_t;

  strobe_t            strobe;
  logic [NUM_BUF-1:0] headHitVec;
  logic [NUM_BUF-1:0] headReadyVec;
  logic [BUF_W-1:0]   lruBuf;
  logic               hitAny;

  sb_ctrl #(
    .NUM_BUF (NUM_BUF),
    .strobe_t(strobe_t)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .headHitVec  (headHitVec),
    .headReadyVec(headReadyVec),
    .lruBuf      (lruBuf),
    .missReady   (missReady),
    .respValid   (respValid),
    .respHit     (respHit),
    .hitAny      (hitAny),
    .strobe      (strobe)
  );

  sb_datapath #(
    .NUM_BUF (NUM_BUF),
    .DEPTH   (DEPTH),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .strobe_t(strobe_t)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .missAddr    (missAddr),
    .headHitVec  (headHitVec),
    .headReadyVec(headReadyVec),
    .respData    (respData),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .reqAddr     (reqAddr),
    .reqTag      (reqTag),
    .rspValid    (rspValid),
    .rspTag      (rspTag),
    .rspData     (rspData)
  );

  sb_lru #(
    .NUM_BUF(NUM_BUF)
  ) u_lru (
    .clk     (clk),
    .rstN    (rstN),
    .touchEn (strobe.popEn | strobe.allocEn),
    .touchBuf(strobe.bufSel),
    .lruBuf  (lruBuf)
  );

endmodule

// File: rtl/stream_prefetcher_chk.sv
module stream_prefetcher_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             missValid,
  input logic             missReady,
  input logic             hitAny,
  input logic             respValid,
  input logic             reqValid,
  input logic             reqReady,
  input logic [TAG_W-1:0] reqTag,
  input logic             rspValid,
  input logic [TAG_W-1:0] rspTag
);

  logic [(1 << TAG_W)-1:0] outst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outst <= '0;
    end else begin
      if (rspValid) outst[rspTag] <= 1'b0;
      if (reqValid && reqReady) outst[reqTag] <= 1'b1;
    end
  end

  // R2: a lookup that matches no buffer head is never stalled
  a_r2_miss_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && !hitAny) |-> missReady);

  // R4: every accepted lookup produces a result one cycle later
  a_r4_resp_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady) |=> respValid);

  // R12: a result only appears after an accepted lookup
  a_r12_resp_needs_accept: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(missValid && missReady));

  // R10: no tag is reissued while a response for it is outstanding
  a_r10_no_tag_reissue: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> !outst[reqTag]);

endmodule

bind stream_prefetcher stream_prefetcher_chk #(.TAG_W(TAG_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .missValid(missValid),
  .missReady(missReady),
  .hitAny   (hitAny),
  .respValid(respValid),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqTag   (reqTag),
  .rspValid (rspValid),
  .rspTag   (rspTag)
);

// File: tb/stream_prefetcher_tb_top.sv
module stream_prefetcher_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB     = 4;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;

  logic              clk;
  logic              rstN;
  logic              missValid;
  logic [ADDR_W-1:0] missAddr;
  logic              missReady;
  logic              respValid;
  logic              respHit;
  logic [DATA_W-1:0] respData;
  logic              reqValid;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr;
  logic [TAG_W-1:0]  reqTag;
  logic              rspValid;
  logic [TAG_W-1:0]  rspTag;
  logic [DATA_W-1:0] rspData;

  stream_prefetcher #(
    .NUM_BUF(NB), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missAddr(missAddr), .missReady(missReady),
    .respValid(respValid), .respHit(respHit), .respData(respData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqTag(reqTag),
    .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  function automatic logic [DATA_W-1:0] lineData(input logic [ADDR_W-1:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model of buffer heads and recency
  int mBase [NB];
  bit mActive [NB];
  int mAge [NB];

  function automatic void modelInit();
    for (int i = 0; i < NB; i++) begin
      mBase[i] = 0; mActive[i] = 1'b0; mAge[i] = i;
    end
  endfunction

  function automatic void modelTouch(input int t);
    int old = mAge[t];
    for (int i = 0; i < NB; i++) if (mAge[i] < old) mAge[i]++;
    mAge[t] = 0;
  endfunction

  function automatic bit modelLookup(input int a);
    for (int i = 0; i < NB; i++) begin
      if (mActive[i] && (mBase[i] == a)) begin
        mBase[i]++;
        modelTouch(i);
        return 1'b1;
      end
    end
    for (int i = 0; i < NB; i++) begin
      if (mAge[i] == NB - 1) begin
        mBase[i] = (a + 1) & 16'hFFFF;
        mActive[i] = 1'b1;
        modelTouch(i);
        break;
      end
    end
    return 1'b0;
  endfunction

  // next-level memory model
  logic [TAG_W-1:0]  pTag [64];
  logic [ADDR_W-1:0] pAddr [64];
  int                pCnt = 0;
  bit                hold = 1'b0;
  int                reqCount = 0;
  logic [ADDR_W-1:0] reqLog [256];
  logic [15:0]       lfsr = 16'hACE1;
  int                cyc = 0;

  initial begin
    rspValid = 1'b0; rspTag = '0; rspData = '0; reqReady = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rstN) begin
        pCnt = 0; rspValid = 1'b0; reqReady = 1'b0;
      end else begin
        reqReady = (cyc % 4) != 2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!hold && pCnt > 0 && lfsr[0]) begin
          int idx;
          idx = int'(lfsr[7:1]) % pCnt;
          rspValid = 1'b1;
          rspTag   = pTag[idx];
          rspData  = lineData(pAddr[idx]);
          pCnt--;
          pTag[idx]  = pTag[pCnt];
          pAddr[idx] = pAddr[pCnt];
        end else begin
          rspValid = 1'b0;
        end
        #1;
        if (reqValid && reqReady && pCnt < 64) begin
          pTag[pCnt]  = reqTag;
          pAddr[pCnt] = reqAddr;
          pCnt++;
          if (reqCount < 256) reqLog[reqCount] = reqAddr;
          reqCount++;
        end
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0; missValid = 1'b0; missAddr = '0; hold = 1'b0;
    repeat (3) @(negedge clk);
    modelInit();
    reqCount = 0;
    rstN = 1'b1;
  endtask

  task automatic lookup(input int a, input string req, output int stalls);
    bit expHit;
    stalls = 0;
    @(negedge clk);
    missValid = 1'b1;
    missAddr  = ADDR_W'(a);
    #1;
    while (!missReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    expHit = modelLookup(a);
    @(negedge clk);
    missValid = 1'b0;
    check(respValid == 1'b1, "R12", "result valid after accept", respValid, 1);
    check(respHit == expHit, req, $sformatf("hit flag for line %0h", a), respHit, expHit);
    if (expHit)
      check(respData == lineData(ADDR_W'(a)), expHit ? "R9" : req,
            $sformatf("data for line %0h", a), respData, lineData(ADDR_W'(a)));
  endtask

  task automatic lk(input int a, input string req);
    int st;
    lookup(a, req, st);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int st;
    int sum;
    bit inRange;
    doReset();

    // R1: reset state
    #1;
    check(missReady == 1'b1, "R1", "missReady after reset", missReady, 1);
    check(respValid == 1'b0, "R1", "respValid after reset", respValid, 0);
    check(reqValid == 1'b0, "R1", "reqValid after reset", reqValid, 0);

    // R2/R3: first miss and its prefetch run
    lk(100, "R2");
    repeat (30) @(negedge clk);
    check(reqCount == DEPTH, "R3", "request count after one miss", reqCount, DEPTH);
    sum = 0; inRange = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      sum += int'(reqLog[i]);
      if (reqLog[i] < 101 || reqLog[i] > 100 + DEPTH) inRange = 1'b0;
    end
    check(inRange, "R3", "request addresses in A+1..A+DEPTH", inRange, 1);
    check(sum == 101 + 102 + 103 + 104, "R3", "request address sum", sum, 410);
    #1;
    check(respValid == 1'b0, "R12", "no result while idle", respValid, 0);

    // R11: a line deeper in a buffer is a miss
    lk(102, "R11");
    lk(103, "R11");

    // R6: pending head stalls until data arrives
    doReset();
    hold = 1'b1;
    lk(200, "R2");
    fork
      begin repeat (8) @(negedge clk); hold = 1'b0; end
      begin lookup(201, "R6", st); end
    join
    check(st >= 5, "R6", "stall cycles on pending head", st, 5);

    // R10: restart a buffer while its requests are outstanding
    doReset();
    hold = 1'b1;
    lk(1000, "R8"); lk(2000, "R8"); lk(3000, "R8"); lk(4000, "R8");
    repeat (25) @(negedge clk);
    lk(5000, "R10");
    hold = 1'b0;
    for (int j = 1; j <= 6; j++) lk(5000 + j, "R10");
    lk(1001, "R10");

    // R5: a stream hits well past the buffer depth
    doReset();
    lk(40, "R2");
    for (int j = 41; j <= 60; j++) lk(j, "R5");

    // R8: recency order with hits and allocations
    doReset();
    lk(10, "R8"); lk(20, "R8"); lk(30, "R8"); lk(40, "R8");
    lk(11, "R8");
    lk(50, "R8");
    lk(21, "R8");
    lk(12, "R8");

    // R7/R8 sweep: one to five interleaved streams
    for (int k = 1; k <= NB + 1; k++) begin
      doReset();
      for (int step = 0; step < 8; step++)
        for (int s = 0; s < k; s++)
          lk(s * 256 + 17 * k + step, (k > NB) ? "R8" : "R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule